// File: doc/BRIEF.md
# Dual-Clock Peripheral Bus Bridge

This bridge lets a processor running on a fast clock reach a bank of slow peripherals that run on a separate, unrelated clock. The processor side raises a request with an address, a direction flag and write data. It holds all of these until the bridge answers with a one-cycle completion pulse. On a read, the returned data is valid during that same pulse.

The bridge has two halves, each with its own control FSM. The fast half registers the request and raises a request flag toward the slow half. The slow half runs a two-phase peripheral transfer: a setup cycle, then an enable cycle. It then raises an acknowledge flag and holds the read data stable. Both flags cross between the clocks through two-flop synchronizers.

The fast half answers the processor only after the acknowledge arrives. Before it accepts the next request, it waits until the acknowledge has been withdrawn again. This means the ready indication is always cleared before a new access begins. The upper two address bits select one of four peripherals, and the remaining bits go out as the peripheral address.

Top module: `cdc_bus_bridge`

## Requirements
- R1: While reset is applied and after it is released with no request, cpu_done is 0, every bit of per_sel is 0 and per_enable is 0.
- R2: Each transfer begins with one setup cycle of the slow clock: exactly one per_sel bit is high and per_enable is low. This setup cycle directly follows an idle cycle (all per_sel bits low).
- R3: The slow-clock cycle after the setup cycle is the enable cycle. In it, per_enable is high, and per_sel, per_addr, per_write and per_wdata are unchanged from the setup cycle.
- R4: The slow-clock cycle after the enable cycle is idle: per_sel, per_enable, per_write, per_addr and per_wdata are all 0.
- R5: The index of the high per_sel bit equals cpu_addr[ADDR_W-1:ADDR_W-2]. For example, address 8'hC5 drives per_sel = 4'b1000 and per_addr = 6'h05. per_addr carries cpu_addr[ADDR_W-3:0].
- R6: On a read (cpu_wr = 0), cpu_rdata equals the value of per_rdata during the enable cycle. It is valid in the cycle where cpu_done is high.
- R7: On a write (cpu_wr = 1), the transfer shows per_write = 1 and per_wdata = cpu_wdata. On a read, the transfer shows per_write = 0 and per_wdata = 0.
- R8: cpu_done is a single fast-clock pulse. It occurs only after the peripheral transfer for that request has completed.
- R9: Each request produces exactly one peripheral transfer. Back-to-back requests each get their own transfer, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Processor-side clock |
| fast_rst | input | 1 | Synchronous reset, fast domain, active high |
| slow_clk | input | 1 | Peripheral-side clock |
| slow_rst | input | 1 | Synchronous reset, slow domain, active high |
| cpu_req | input | 1 | Access request; held until cpu_done |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Access address (upper 2 bits pick the peripheral) |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_done |
| cpu_done | output | 1 | One-cycle completion pulse |
| per_sel | output | 2**SEL_W | One-hot peripheral select |
| per_enable | output | 1 | Enable phase strobe |
| per_write | output | 1 | Peripheral write flag |
| per_addr | output | ADDR_W-SEL_W | Peripheral address |
| per_wdata | output | DATA_W | Peripheral write data |
| per_rdata | input | DATA_W | Peripheral read data |

## Verification
After the fast FSM registers a request, the request flag passes two slow-clock synchronizer flops. The setup cycle therefore appears 3 to 4 slow edges after the request. The enable cycle follows exactly one slow edge later, and the idle cycle one edge after that. Because the clocks are unrelated, the acknowledge takes 3 to 4 fast edges to produce cpu_done.

The bench never waits a fixed number of cycles for the variable crossing delay. It samples at the falling edge of the fast clock until cpu_done appears, with a bounded timeout, and checks the read data in that cycle. A separate monitor checks the peripheral phases at every falling slow edge, against the previous phase it observed, so the fixed one-cycle setup-to-enable-to-idle spacing is checked exactly.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {F_IDLE, F_ISSUE, F_RESP, F_DRAIN} fast_st_e;
  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ENABLE, S_ACK} slow_st_e;
endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bridge_fast_side.sv
module bridge_fast_side import bridge_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  // link toward slow half
  output logic              x_req,
  output logic              x_write,
  output logic [ADDR_W-1:0] x_addr,
  output logic [DATA_W-1:0] x_wdata,
  input  logic              ack_sync,
  input  logic [DATA_W-1:0] x_rdata
);
  fast_st_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= F_IDLE;
      x_req     <= 1'b0;
      x_write   <= 1'b0;
      x_addr    <= '0;
      x_wdata   <= '0;
      cpu_rdata <= '0;
    end else begin
      unique case (state)
        F_IDLE: if (cpu_req) begin
          // operands are frozen before the flag is raised
          x_addr  <= cpu_addr;
          x_write <= cpu_wr;
          x_wdata <= cpu_wr ? cpu_wdata : '0;
          x_req   <= 1'b1;
          state   <= F_ISSUE;
        end
        F_ISSUE: if (ack_sync) begin
          cpu_rdata <= x_rdata;
          x_req     <= 1'b0;
          state     <= F_RESP;
        end
        F_RESP:  state <= F_DRAIN;
        F_DRAIN: if (!ack_sync) state <= F_IDLE;
        default: state <= F_IDLE;
      endcase
    end
  end

  assign cpu_done = (state == F_RESP);
endmodule

// File: rtl/bridge_slow_side.sv
module bridge_slow_side import bridge_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_sync,
  input  logic                   x_write,
  input  logic [ADDR_W-1:0]      x_addr,
  input  logic [DATA_W-1:0]      x_wdata,
  output logic                   x_ack,
  output logic [DATA_W-1:0]      x_rdata,
  output logic [(1<<SEL_W)-1:0]  per_sel,
  output logic                   per_enable,
  output logic                   per_write,
  output logic [ADDR_W-SEL_W-1:0] per_addr,
  output logic [DATA_W-1:0]      per_wdata,
  input  logic [DATA_W-1:0]      per_rdata
);
  localparam int NPER    = 1 << SEL_W;
  localparam int PADDR_W = ADDR_W - SEL_W;

  function automatic logic [NPER-1:0] sel_decode(input logic [SEL_W-1:0] idx);
    logic [NPER-1:0] v;
    v      = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  slow_st_e state;
  logic     active;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      x_ack   <= 1'b0;
      x_rdata <= '0;
    end else begin
      unique case (state)
        S_IDLE:   if (req_sync && !x_ack) state <= S_SETUP;
        S_SETUP:  state <= S_ENABLE;
        S_ENABLE: begin
          x_rdata <= x_write ? '0 : per_rdata;
          x_ack   <= 1'b1;
          state   <= S_ACK;
        end
        S_ACK: if (!req_sync) begin
          x_ack <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign active     = (state == S_SETUP) || (state == S_ENABLE);
  assign per_sel    = active ? sel_decode(x_addr[ADDR_W-1 -: SEL_W]) : '0;
  assign per_enable = (state == S_ENABLE);
  assign per_write  = active & x_write;
  assign per_addr   = active ? x_addr[PADDR_W-1:0] : '0;
  assign per_wdata  = (active && x_write) ? x_wdata : '0;
endmodule

// File: rtl/cdc_bus_bridge.sv
module cdc_bus_bridge #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2,
  parameter int SYNC_N = 2
) (
  input  logic                    fast_clk,
  input  logic                    fast_rst,
  input  logic                    slow_clk,
  input  logic                    slow_rst,
  input  logic                    cpu_req,
  input  logic                    cpu_wr,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    cpu_done,
  output logic [(1<<SEL_W)-1:0]   per_sel,
  output logic                    per_enable,
  output logic                    per_write,
  output logic [ADDR_W-SEL_W-1:0] per_addr,
  output logic [DATA_W-1:0]       per_wdata,
  input  logic [DATA_W-1:0]       per_rdata
);
  logic              x_req, x_ack, req_sync, ack_sync, x_write;
  logic [ADDR_W-1:0] x_addr;
  logic [DATA_W-1:0] x_wdata, x_rdata;

  bridge_fast_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fast (
    .clk(fast_clk), .rst(fast_rst),
    .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
    .x_req(x_req), .x_write(x_write), .x_addr(x_addr), .x_wdata(x_wdata),
    .ack_sync(ack_sync), .x_rdata(x_rdata)
  );

  bridge_sync #(.STAGES(SYNC_N)) u_req_sync (
    .clk(slow_clk), .rst(slow_rst), .d(x_req), .q(req_sync)
  );

  bridge_sync #(.STAGES(SYNC_N)) u_ack_sync (
    .clk(fast_clk), .rst(fast_rst), .d(x_ack), .q(ack_sync)
  );

  bridge_slow_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_slow (
    .clk(slow_clk), .rst(slow_rst), .req_sync(req_sync),
    .x_write(x_write), .x_addr(x_addr), .x_wdata(x_wdata),
    .x_ack(x_ack), .x_rdata(x_rdata),
    .per_sel(per_sel), .per_enable(per_enable), .per_write(per_write),
    .per_addr(per_addr), .per_wdata(per_wdata), .per_rdata(per_rdata)
  );
endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input logic                    fast_clk,
  input logic                    fast_rst,
  input logic                    slow_clk,
  input logic                    slow_rst,
  input logic                    cpu_done,
  input logic [(1<<SEL_W)-1:0]   per_sel,
  input logic                    per_enable,
  input logic                    per_write,
  input logic [ADDR_W-SEL_W-1:0] per_addr,
  input logic [DATA_W-1:0]       per_wdata
);
  logic setup_phase;
  assign setup_phase = (per_sel != '0) && !per_enable;

  // R3
  setup_to_enable_chk: assert property (@(posedge slow_clk) disable iff (slow_rst)
    setup_phase |=> (per_enable && $stable(per_sel) && $stable(per_addr) && $stable(per_wdata)));

  // R4
  enable_to_idle_chk: assert property (@(posedge slow_clk) disable iff (slow_rst)
    per_enable |=> (per_sel == '0 && !per_enable && !per_write && per_addr == '0));

  // R5
  sel_onehot_chk: assert property (@(posedge slow_clk) disable iff (slow_rst)
    $onehot0(per_sel) && (per_enable -> per_sel != '0));

  // R7
  read_wdata_zero_chk: assert property (@(posedge slow_clk) disable iff (slow_rst)
    (per_sel != '0 && !per_write) |-> per_wdata == '0);

  // R8
  done_pulse_chk: assert property (@(posedge fast_clk) disable iff (fast_rst)
    cpu_done |=> !cpu_done);
endmodule

bind cdc_bus_bridge bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_bridge_chk (
  .fast_clk(fast_clk), .fast_rst(fast_rst), .slow_clk(slow_clk), .slow_rst(slow_rst),
  .cpu_done(cpu_done), .per_sel(per_sel), .per_enable(per_enable),
  .per_write(per_write), .per_addr(per_addr), .per_wdata(per_wdata)
);

// File: tb/test_cdc_bus_bridge.sv
`timescale 1ns/1ps
module test_cdc_bus_bridge;
  localparam int AW = 8, DW = 8, SW = 2, NP = 4, PW = 6;

  logic fast_clk = 0, slow_clk = 0, fast_rst = 1, slow_rst = 1;
  logic cpu_req = 0, cpu_wr = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata, per_wdata, per_rdata;
  logic cpu_done, per_enable, per_write;
  logic [NP-1:0] per_sel;
  logic [PW-1:0] per_addr;

  always #2.5 fast_clk = ~fast_clk;
  always #8.5 slow_clk = ~slow_clk;

  cdc_bus_bridge i_cdc_bus_bridge (
    .fast_clk(fast_clk), .fast_rst(fast_rst), .slow_clk(slow_clk), .slow_rst(slow_rst),
    .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
    .per_sel(per_sel), .per_enable(per_enable), .per_write(per_write),
    .per_addr(per_addr), .per_wdata(per_wdata), .per_rdata(per_rdata)
  );

  int tests = 0, fails = 0, xfers = 0, phase = 0;
  logic [DW-1:0] pmem [NP][1<<PW];
  logic [DW-1:0] model [NP][1<<PW];
  logic [NP-1:0] exp_sel;
  logic [PW-1:0] exp_paddr;
  logic exp_wr;
  logic [DW-1:0] exp_wdata, en_rdata;

  function automatic logic [NP-1:0] onehot_of(input logic [AW-1:0] a);
    return 4'b0001 << a[7:6];
  endfunction

  function automatic int idx_of(input logic [NP-1:0] s);
    int r = 0;
    for (int k = 0; k < NP; k++) if (s[k]) r = k;
    return r;
  endfunction

  always_comb begin
    if (per_sel != '0) per_rdata = pmem[idx_of(per_sel)][per_addr];
    else per_rdata = '0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // peripheral-side phase monitor
  always @(negedge slow_clk) begin
    if (!slow_rst) begin
      if (per_sel == '0 && !per_enable) begin
        if (phase == 2) begin
          chk(per_write == 0 && per_addr == 0 && per_wdata == 0, "R4 idle after enable", per_wdata, 0);
        end
        if (phase == 1) chk(0, "R3 enable missing", 0, 1);
        phase = 0;
      end else if (!per_enable) begin
        chk(phase == 0, "R2 setup after idle", phase, 0);
        chk(per_sel == exp_sel, "R5 select decode", per_sel, exp_sel);
        chk(per_addr == exp_paddr, "R5 peripheral address", per_addr, exp_paddr);
        chk(per_write == exp_wr, "R7 write flag", per_write, exp_wr);
        chk(per_wdata == (exp_wr ? exp_wdata : 8'h00), "R7 write data", per_wdata, exp_wdata);
        xfers++;
        phase = 1;
      end else begin
        chk(phase == 1, "R3 enable after setup", phase, 1);
        chk(per_sel == exp_sel && per_addr == exp_paddr, "R3 held select/address", per_addr, exp_paddr);
        en_rdata = per_rdata;
        if (per_write) pmem[idx_of(per_sel)][per_addr] = per_wdata;
        phase = 2;
      end
    end
  end

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int x0, t;
    logic [DW-1:0] expr;
    @(negedge fast_clk);
    exp_sel = onehot_of(a); exp_paddr = a[PW-1:0]; exp_wr = wr; exp_wdata = d;
    expr = model[a[7:6]][a[PW-1:0]];
    x0 = xfers;
    cpu_req = 1; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    t = 0;
    do begin
      @(negedge fast_clk);
      t++;
    end while (!cpu_done && t < 400);
    chk(cpu_done, "R8 done arrives", cpu_done, 1);
    chk(xfers == x0 + 1, "R9 one transfer per request", xfers - x0, 1);
    chk(phase == 2 || phase == 0, "R8 done after transfer", phase, 2);
    if (!wr) begin
      chk(cpu_rdata == expr, "R6 read data", cpu_rdata, expr);
      chk(cpu_rdata == en_rdata, "R6 matches enable-cycle data", cpu_rdata, en_rdata);
    end else model[a[7:6]][a[PW-1:0]] = d;
    cpu_req = 0;
    @(negedge fast_clk);
    chk(!cpu_done, "R8 single pulse", cpu_done, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < (1<<PW); a++) begin
        pmem[p][a]  = 8'(p*53 + a*7 + 1);
        model[p][a] = 8'(p*53 + a*7 + 1);
      end
    repeat (10) @(posedge slow_clk);
    @(negedge fast_clk);
    chk(!cpu_done && per_sel == 0 && !per_enable, "R1 state during reset", per_sel, 0);
    fast_rst = 0; slow_rst = 0;
    repeat (20) @(negedge fast_clk);
    chk(!cpu_done && per_sel == 0 && !per_enable, "R1 idle after reset", per_sel, 0);
    // directed corners: each peripheral, lowest and highest offsets
    for (int p = 0; p < NP; p++) begin
      access(0, 8'(p*64), 8'h00);
      access(1, 8'(p*64 + 63), 8'(8'hA0 + p));
      access(0, 8'(p*64 + 63), 8'h00);
    end
    access(1, 8'hC5, 8'hFF);
    access(0, 8'hC5, 8'h00);
    // random mix
    for (int i = 0; i < 80; i++) begin
      bit w;
      logic [AW-1:0] a;
      w = $urandom_range(0, 1) == 1;
      a = 8'($urandom_range(0, 255));
      access(w, a, 8'($urandom_range(0, 255)));
    end
    repeat (10) @(negedge fast_clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge fast_clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule